// File: doc/BRIEF.md
# Descriptor Entry List Walker

This block reads a descriptor image from a byte-addressed buffer and walks the chain of variable-length entries that begins right after a fixed 22-byte header. Entries are not linked by pointers. Each entry starts with its own length byte, and the position of the next entry is the current position plus that length. For every entry the block decides whether it is a port entry. For port entries it decodes a few packed bits into a per-port configuration record.

The records live in a 64-slot table indexed by the entry's 6-bit index. Software or a neighbouring block reads the table through a combinational query port. A walk is launched by a one-cycle `start` pulse together with the total image size. When the walk finishes or stops on a malformed entry, `done` rises with an error code. The buffer is read through a synchronous port: the address and `rd_en` go out in one cycle, and the byte comes back on `rd_data` in the next cycle.

Top module: `dlw_list_walker`

## Requirements
- R1: After reset, `done` is 0, `err` is 0 and every table record reads as all zero.
- R2: A `start` pulse accepted while idle or done clears every record to zero and begins the walk at byte offset 22. If the image size is 22 or less, the walk ends with `done`=1 and `err`=0 (no error).
- R3: An entry whose second byte has bit 7 clear is a generic entry. It is skipped and changes no record.
- R4: For a port entry (second byte bit 7 set), the record at index = second byte bits [5:0] takes disabled = second byte bit 6. When that bit is set, no other field of the record changes and the entry length is not checked.
- R5: For an enabled port entry of length 8:
  - link = bit 4 of entry byte 2.
  - dual_valid = bit 7 of entry byte 2.
  - dual_idx = bits [5:0] of entry byte 3 when dual_valid is 1, and 0 otherwise.
  - disabled = 0.
- R6: An enabled port entry whose length is not 8 ends the walk with `err` = 2 (port length error).
- R7: If the current position equals size minus one, the walk ends with `err` = 1 (overrun).
- R8: If the current position plus the entry length exceeds the size, the walk ends with `err` = 1 (overrun).
- R9: An entry length of zero ends the walk with `err` = 1 (overrun).
- R10: After each entry the position advances by its length. A chain that ends exactly at the size completes with `err` = 0. The buffer is never read at or beyond the size.
- R11: Records written before an abort keep their values. `done` and `err` hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a walk (accepted while idle or done) |
| image_size | input | 11 | Total image size in bytes, captured at start |
| rd_en | output | 1 | Buffer read request |
| rd_addr | output | 11 | Buffer byte address |
| rd_data | input | 8 | Buffer byte, one cycle after the request |
| done | output | 1 | Walk finished or aborted |
| err | output | 2 | 0 none, 1 overrun, 2 port length error |
| q_idx | input | 6 | Table query index |
| q_disabled | output | 1 | Queried record: disabled flag |
| q_link | output | 1 | Queried record: link number |
| q_dual_valid | output | 1 | Queried record: partner present |
| q_dual_idx | output | 6 | Queried record: partner port index |

## Verification
The assertions check the following on every cycle:
- A non-zero error code appears only while `done` is high.
- A zero length byte or a wrongly sized enabled port entry is followed one cycle later by the matching abort code.
- Every buffer read lies inside the image.
- A table write happens only during a walk.
- `done` holds until a new start.

The decoded record contents, the skipping of generic entries, and the preservation of records across an abort depend on whole images. Only the bench's scenarios can show them, by querying the table after each walk.

// File: rtl/dlw_pkg.sv
`timescale 1ns/1ps
package dlw_pkg;
  localparam int IDX_W = 6;

  typedef struct packed {
    logic             disabled;
    logic             link;
    logic             dual_valid;
    logic [IDX_W-1:0] dual_idx;
  } port_rec_t;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_OVERRUN  = 2'd1,
    ERR_PORT_LEN = 2'd2
  } err_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_LEN, S_HDR, S_B2, S_B3, S_DONE
  } state_t;

  // Zero length, or an entry reaching past the image end.
  function automatic logic len_overrun(input logic [15:0] pos,
                                       input logic [7:0]  len,
                                       input logic [15:0] size);
    return (len == 8'd0) || (({1'b0, pos} + 17'(len)) > {1'b0, size});
  endfunction

  function automatic logic hdr_is_port(input logic [7:0] b);
    return b[7];
  endfunction

  function automatic logic hdr_disabled(input logic [7:0] b);
    return b[6];
  endfunction

  function automatic logic [IDX_W-1:0] hdr_index(input logic [7:0] b);
    return b[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/dlw_table.sv
`timescale 1ns/1ps
module dlw_table
  import dlw_pkg::*;
#(
  parameter int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             we,
  input  logic             dis_only,
  input  logic [IDX_W-1:0] widx,
  input  port_rec_t        wdata,
  input  logic [IDX_W-1:0] ridx,
  output port_rec_t        rdata
);
  port_rec_t ent_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit;
    assign hit = we && (widx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[i] <= '0;
      end else if (clear) begin
        ent_q[i] <= '0;
      end else if (hit) begin
        if (dis_only) ent_q[i].disabled <= wdata.disabled;
        else          ent_q[i]          <= wdata;
      end
    end
  end

  assign rdata = ent_q[ridx];
endmodule

// File: rtl/dlw_walker.sv
`timescale 1ns/1ps
module dlw_walker
  import dlw_pkg::*;
#(
  parameter int SIZE_W    = 11,
  parameter int HDR_BYTES = 22,
  parameter int PORT_LEN  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] size_in,
  output logic              rd_en,
  output logic [SIZE_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              tbl_clear,
  output logic              tbl_we,
  output logic              tbl_dis_only,
  output logic [IDX_W-1:0]  tbl_widx,
  output port_rec_t         tbl_wdata,
  output logic              done,
  output logic [1:0]        err,
  output logic              busy,
  output logic [SIZE_W-1:0] size_q,
  output logic              evt_len_chk,
  output logic              evt_port_len_bad
);
  state_t            st;
  err_t              err_q;
  logic [SIZE_W-1:0] pos_q;
  logic [7:0]        len_q;
  logic              link_q, dual_q;
  logic [IDX_W-1:0]  idx_q;

  logic              pos_at_end, pos_last, ovr_len;
  logic              hdr_port, hdr_dis, len_is_port;
  logic [SIZE_W-1:0] pos_next;
  logic              idle_like;

  assign idle_like   = (st == S_IDLE) || (st == S_DONE);
  assign pos_at_end  = pos_q >= size_q;
  assign pos_last    = ({1'b0, pos_q} + (SIZE_W+1)'(1)) == {1'b0, size_q};
  assign ovr_len     = len_overrun(16'(pos_q), rd_data, 16'(size_q));
  assign hdr_port    = hdr_is_port(rd_data);
  assign hdr_dis     = hdr_disabled(rd_data);
  assign len_is_port = len_q == 8'(PORT_LEN);
  assign pos_next    = pos_q + SIZE_W'(len_q);

  assign busy             = !idle_like;
  assign done             = st == S_DONE;
  assign err              = err_q;
  assign tbl_clear        = idle_like && start;
  assign evt_len_chk      = st == S_LEN;
  assign evt_port_len_bad = (st == S_HDR) && hdr_port && !hdr_dis && !len_is_port;

  // Buffer requests: the byte is consumed in the following state.
  always_comb begin
    rd_en   = 1'b0;
    rd_addr = pos_q;
    unique case (st)
      S_CHK: begin rd_en = !pos_at_end && !pos_last;            rd_addr = pos_q; end
      S_LEN: begin rd_en = !ovr_len;                            rd_addr = pos_q + SIZE_W'(1); end
      S_HDR: begin rd_en = hdr_port && !hdr_dis && len_is_port; rd_addr = pos_q + SIZE_W'(2); end
      S_B2:  begin rd_en = 1'b1;                                rd_addr = pos_q + SIZE_W'(3); end
      default: ;
    endcase
  end

  // Record writes: disabled flag at the header byte, full record at byte 3.
  always_comb begin
    tbl_we       = 1'b0;
    tbl_dis_only = 1'b0;
    tbl_widx     = idx_q;
    tbl_wdata    = '0;
    if (st == S_HDR && hdr_port) begin
      tbl_we             = 1'b1;
      tbl_dis_only       = 1'b1;
      tbl_widx           = hdr_index(rd_data);
      tbl_wdata.disabled = hdr_dis;
    end else if (st == S_B3) begin
      tbl_we               = 1'b1;
      tbl_wdata.link       = link_q;
      tbl_wdata.dual_valid = dual_q;
      tbl_wdata.dual_idx   = dual_q ? rd_data[IDX_W-1:0] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      err_q  <= ERR_NONE;
      pos_q  <= '0;
      size_q <= '0;
      len_q  <= '0;
      link_q <= 1'b0;
      dual_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      unique case (st)
        S_IDLE, S_DONE: if (start) begin
          pos_q  <= SIZE_W'(HDR_BYTES);
          size_q <= size_in;
          err_q  <= ERR_NONE;
          st     <= S_CHK;
        end
        S_CHK: begin
          if (pos_at_end) st <= S_DONE;
          else if (pos_last) begin
            err_q <= ERR_OVERRUN;
            st    <= S_DONE;
          end else st <= S_LEN;
        end
        S_LEN: begin
          len_q <= rd_data;
          if (ovr_len) begin
            err_q <= ERR_OVERRUN;
            st    <= S_DONE;
          end else st <= S_HDR;
        end
        S_HDR: begin
          idx_q <= hdr_index(rd_data);
          if (!hdr_port || hdr_dis) begin
            pos_q <= pos_next;
            st    <= S_CHK;
          end else if (!len_is_port) begin
            err_q <= ERR_PORT_LEN;
            st    <= S_DONE;
          end else st <= S_B2;
        end
        S_B2: begin
          link_q <= rd_data[4];
          dual_q <= rd_data[7];
          st     <= S_B3;
        end
        S_B3: begin
          pos_q <= pos_next;
          st    <= S_CHK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dlw_list_walker.sv
`timescale 1ns/1ps
module dlw_list_walker
  import dlw_pkg::*;
#(
  parameter int SIZE_W    = 11,
  parameter int HDR_BYTES = 22,
  parameter int PORT_LEN  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] image_size,
  output logic              rd_en,
  output logic [SIZE_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              done,
  output logic [1:0]        err,
  input  logic [IDX_W-1:0]  q_idx,
  output logic              q_disabled,
  output logic              q_link,
  output logic              q_dual_valid,
  output logic [IDX_W-1:0]  q_dual_idx
);
  logic              tbl_clear, tbl_we, tbl_dis_only;
  logic [IDX_W-1:0]  tbl_widx;
  port_rec_t         tbl_wdata, q_rec;
  logic              busy, evt_len_chk, evt_port_len_bad;
  logic [SIZE_W-1:0] size_q;

  dlw_walker #(.SIZE_W(SIZE_W), .HDR_BYTES(HDR_BYTES), .PORT_LEN(PORT_LEN)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .size_in(image_size),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tbl_clear(tbl_clear), .tbl_we(tbl_we), .tbl_dis_only(tbl_dis_only),
    .tbl_widx(tbl_widx), .tbl_wdata(tbl_wdata),
    .done(done), .err(err), .busy(busy), .size_q(size_q),
    .evt_len_chk(evt_len_chk), .evt_port_len_bad(evt_port_len_bad)
  );

  dlw_table u_tbl (
    .clk(clk), .rst_n(rst_n), .clear(tbl_clear), .we(tbl_we),
    .dis_only(tbl_dis_only), .widx(tbl_widx), .wdata(tbl_wdata),
    .ridx(q_idx), .rdata(q_rec)
  );

  assign q_disabled   = q_rec.disabled;
  assign q_link       = q_rec.link;
  assign q_dual_valid = q_rec.dual_valid;
  assign q_dual_idx   = q_rec.dual_idx;
endmodule

// File: rtl/dlw_checker.sv
`timescale 1ns/1ps
module dlw_checker #(
  parameter int SIZE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic [1:0]        err,
  input logic              busy,
  input logic              rd_en,
  input logic [SIZE_W-1:0] rd_addr,
  input logic [SIZE_W-1:0] size_q,
  input logic [7:0]        len_byte,
  input logic              evt_len_chk,
  input logic              evt_port_len_bad,
  input logic              tbl_we,
  input logic              tbl_clear
);
  assert_err_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err != 2'd0) |-> done);

  assert_len_zero_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_len_chk && len_byte == 8'd0) |=> (done && err == 2'd1));

  assert_bad_port_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_port_len_bad |=> (done && err == 2'd2));

  assert_read_inside_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr < size_q));

  assert_done_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_write_in_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> busy);

  assert_clear_begins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_clear |=> (busy && !done));
endmodule

bind dlw_list_walker dlw_checker #(.SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
  .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr), .size_q(size_q),
  .len_byte(rd_data), .evt_len_chk(evt_len_chk),
  .evt_port_len_bad(evt_port_len_bad), .tbl_we(tbl_we), .tbl_clear(tbl_clear)
);

// File: tb/dlw_list_walker_tb.sv
`timescale 1ns/1ps
module dlw_list_walker_tb;
  localparam int SIZE_W = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [SIZE_W-1:0] image_size = '0;
  logic              rd_en;
  logic [SIZE_W-1:0] rd_addr;
  logic [7:0]        rd_data = 8'h00;
  logic              done;
  logic [1:0]        err;
  logic [5:0]        q_idx = '0;
  logic              q_disabled, q_link, q_dual_valid;
  logic [5:0]        q_dual_idx;

  logic [7:0] mem [256];
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[7:0]];

  dlw_list_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .image_size(image_size),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .err(err), .q_idx(q_idx), .q_disabled(q_disabled),
    .q_link(q_link), .q_dual_valid(q_dual_valid), .q_dual_idx(q_dual_idx)
  );

  // Vector: {index, disabled, link, dual_valid, dual_idx[5:0]}
  localparam logic [14:0] VEC [8] = '{
    {6'd3,  9'b0_0_0_000000},
    {6'd5,  9'b0_1_1_000110},
    {6'd6,  9'b0_1_0_000000},
    {6'd9,  9'b1_0_0_000000},
    {6'd10, 9'b0_0_0_000000},
    {6'd63, 9'b0_0_1_010101},
    {6'd0,  9'b0_0_0_000000},
    {6'd7,  9'b0_0_0_000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wipe();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic put4(input int a, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b2, input logic [7:0] b3);
    mem[a] = b0; mem[a+1] = b1; mem[a+2] = b2; mem[a+3] = b3;
  endtask

  task automatic walk(input int size);
    int t;
    @(negedge clk);
    image_size = SIZE_W'(size);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
  endtask

  function automatic logic [31:0] rec_at(input logic [5:0] idx);
    q_idx = idx;
    return 32'({q_disabled, q_link, q_dual_valid, q_dual_idx});
  endfunction

  task automatic check_rec(input string req, input logic [5:0] idx, input logic [8:0] exp);
    q_idx = idx;
    #0.5;
    check(req, 32'({q_disabled, q_link, q_dual_valid, q_dual_idx}), 32'(exp));
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    wipe();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done", 32'(done), 0);
    check("R1 err", 32'(err), 0);
    check_rec("R1 record", 6'd5, 9'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R10: mixed chain ending exactly at size 58
    put4(22, 8'h05, 8'h03, 8'hFF, 8'hFF); mem[26] = 8'hFF;
    put4(27, 8'h08, 8'h85, 8'h90, 8'h06);
    put4(35, 8'h08, 8'h86, 8'h10, 8'h3F);
    put4(43, 8'h03, 8'hC9, 8'hFF, 8'h00);
    put4(46, 8'h04, 8'h0A, 8'hFF, 8'hFF);
    put4(50, 8'h08, 8'hBF, 8'h80, 8'h15);
    walk(58);
    check("R10 done", 32'(done), 1);
    check("R10 err", 32'(err), 0);
    for (int i = 0; i < 8; i++) begin
      check_rec("R3/R4/R5 record", VEC[i][14:9], VEC[i][8:0]);
    end

    // R2: size at header end, previous records cleared
    walk(22);
    check("R2 done", 32'(done), 1);
    check("R2 err", 32'(err), 0);
    check_rec("R2 cleared", 6'd5, 9'd0);

    // R7: position lands on size minus one
    wipe();
    put4(22, 8'h04, 8'h01, 8'h00, 8'h00);
    walk(27);
    check("R7 done", 32'(done), 1);
    check("R7 err", 32'(err), 1);

    // R8 R11: entry runs past end after a good port entry
    wipe();
    put4(22, 8'h08, 8'h82, 8'h10, 8'h00);
    put4(30, 8'h0B, 8'h00, 8'h00, 8'h00);
    walk(40);
    check("R8 err", 32'(err), 1);
    check_rec("R11 kept record", 6'd2, 9'b0_1_0_000000);
    repeat (5) @(negedge clk);
    check("R11 done held", 32'(done), 1);
    check("R11 err held", 32'(err), 1);

    // R9: zero length
    wipe();
    walk(30);
    check("R9 done", 32'(done), 1);
    check("R9 err", 32'(err), 1);
    check_rec("R2 clear on restart", 6'd2, 9'd0);

    // R6: enabled port entry of length 7
    wipe();
    put4(22, 8'h07, 8'h84, 8'h90, 8'h05);
    walk(40);
    check("R6 done", 32'(done), 1);
    check("R6 err", 32'(err), 2);
    check_rec("R6 record", 6'd4, 9'd0);

    // R2: size below the header
    walk(10);
    check("R2 small done", 32'(done), 1);
    check("R2 small err", 32'(err), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule